// File: doc/BRIEF.md
# Byte-Stepped I2C Bus Master

This block is a single-master I2C controller that a processor drives one byte at a time through three small registers: a control register, a status/command register and a data register. A status write in a master mode with the start bit set produces a START condition on the bus and shifts out the data register as the address byte. After the acknowledge clock of every byte the controller sets a pending flag and freezes with SCL pulled low. Software then loads the next byte, or changes direction, or requests a repeated START or a STOP. Clearing the pending flag carries out that next step.

The bus pins are open-drain. The block only asserts `scl_low` / `sda_low` to pull a line down and observes the resolved wire levels on `scl_in` / `sda_in`. Bus busy is derived from the START and STOP conditions seen on those wires. The bit clock comes from a prescaler of 16 or 512 followed by a 4-bit divider.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control, status and data registers read 0, irq is low and neither bus line is pulled low.
- R2: Control register layout is bit7 acknowledge enable, bit6 prescale select (1 selects PRE_HI=512, 0 selects PRE_LO=16), bit5 interrupt enable, bit4 pending, and bits 3:0 the divider. The spacing between SCL rising edges inside a byte is prescale×(divider+1) clocks.
- R3: A status write made with no byte pending, with bit7=1, bit4=1 and bit5=1, produces a START and then sends the data register MSB first. Any other status write made with no byte pending causes no bus activity.
- R4: Pending (control bit4) sets after the acknowledge clock of each byte, and only while the bus is busy. From the following cycle, irq equals pending AND interrupt enable.
- R5: While pending is set, SCL is held low and the bus does not move. Writing the control register with bit4=1 leaves pending set.
- R6: Status bit5 reads bus busy. It sets on a START seen on the wires (SDA falls while SCL is high) and clears on a STOP (SDA rises while SCL is high). Status bit0 reads SDA as sampled in the last acknowledge clock, where 1 means NACK. Bits 7:6 and 4 read back as written.
- R7: In transmit mode (status bits 7:6 = 11), clearing pending with no command queued sends the data register as the next byte.
- R8: In receive mode (status bits 7:6 = 10), clearing pending receives the next byte into the data register. During that byte's acknowledge clock the master drives SDA low only when control bit7 is set.
- R9: A status write with bit5=1 while pending is set queues a repeated START. The following clear of pending produces that repeated START and then sends the data register as the address byte, with busy held at 1 throughout.
- R10: A status write with bit5=0 while pending is set queues a STOP. The following clear of pending produces a STOP and leaves both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_data | input | 8 | Register write value |
| ctrl_q | output | 8 | Control register read value |
| stat_q | output | 8 | Status register read value |
| data_q | output | 8 | Data register read value |
| irq | output | 1 | Interrupt request (pending and enabled) |
| scl_in | input | 1 | Resolved SCL wire level |
| sda_in | input | 1 | Resolved SDA wire level |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_low | output | 1 | Pull SDA low when 1 |

## Verification
The assertions check several rules on every cycle. SCL must be low whenever pending is set. Pending may only rise inside a busy period. Busy may only rise right after a START seen on the wires and only fall right after a STOP. The register file must be cleared by reset. The bench scenarios are needed for the rest. These are the byte values the slave model receives or returns, the acknowledge sampling in both directions, the SCL spacing for each prescale, the repeated-START sequence, and the status writes that must be ignored in the idle state.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
  localparam int DIV_W = 4;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_BIT, E_HOLD, E_STOP
  } eng_state_t;

  typedef enum logic [1:0] {
    C_NEXT, C_RESTART, C_STOP
  } step_cmd_t;
endpackage

// File: rtl/i2cbm_tick.sv
module i2cbm_tick #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512,
  parameter int DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_hi,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  // one phase is a quarter of an SCL period
  localparam int Q_LO  = PRE_LO / 4;
  localparam int Q_HI  = PRE_HI / 4;
  localparam int CNT_W = $clog2(Q_HI * (2 ** DIV_W)) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = CNT_W'((pre_hi ? Q_HI : Q_LO) * (int'(div_sel) + 1) - 1);
    tick = run && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cbm_busmon.sv
module i2cbm_busmon (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  logic scl_q, sda_q;
  logic start_seen, stop_seen;

  always_comb begin
    start_seen = scl_q && scl_in && sda_q && !sda_in;
    stop_seen  = scl_q && scl_in && !sda_q && sda_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_seen)     busy <= 1'b1;
      else if (stop_seen) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cbm_engine.sv
module i2cbm_engine
  import i2cbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start_req,
  input  logic       go,
  input  step_cmd_t  go_cmd,
  input  logic       rx_mode,
  input  logic       ack_gen,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       run,
  output logic       scl_low,
  output logic       sda_low,
  output logic       byte_done,
  output logic       rx_load,
  output logic [7:0] rx_byte,
  output logic       ack_seen
);
  eng_state_t st;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] txsh;
  logic       addr_byte;
  logic       is_tx;
  logic       scl_d, sda_d;

  always_comb begin
    is_tx = addr_byte || !rx_mode;
    run   = (st == E_START) || (st == E_BIT) || (st == E_STOP);
    scl_d = 1'b0;
    sda_d = 1'b0;
    case (st)
      E_START: begin
        scl_d = (ph == 2'd0) || (ph == 2'd3);
        sda_d = (ph == 2'd2) || (ph == 2'd3);
      end
      E_BIT: begin
        scl_d = (ph == 2'd0) || (ph == 2'd3);
        if (bitn == 4'd8) sda_d = !is_tx && ack_gen;
        else              sda_d = is_tx && !txsh[7];
      end
      E_HOLD: scl_d = 1'b1;
      E_STOP: begin
        scl_d = (ph == 2'd0);
        sda_d = (ph != 2'd2);
      end
      default: begin
        scl_d = 1'b0;
        sda_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      ph        <= '0;
      bitn      <= '0;
      txsh      <= '0;
      rx_byte   <= '0;
      addr_byte <= 1'b0;
      ack_seen  <= 1'b0;
      byte_done <= 1'b0;
      rx_load   <= 1'b0;
      scl_low   <= 1'b0;
      sda_low   <= 1'b0;
    end else begin
      scl_low   <= scl_d;
      sda_low   <= sda_d;
      byte_done <= 1'b0;
      rx_load   <= 1'b0;
      case (st)
        E_IDLE: if (start_req) begin
          st        <= E_START;
          ph        <= 2'd1;
          txsh      <= tx_byte;
          addr_byte <= 1'b1;
        end
        E_START: if (tick) begin
          if (ph == 2'd3) begin
            st   <= E_BIT;
            ph   <= 2'd0;
            bitn <= '0;
          end else ph <= ph + 2'd1;
        end
        E_BIT: if (tick) begin
          if (ph == 2'd1) begin
            if (bitn == 4'd8) ack_seen <= sda_in;
            else              rx_byte  <= {rx_byte[6:0], sda_in};
          end
          if (ph == 2'd3) begin
            ph <= 2'd0;
            if (bitn == 4'd8) begin
              st        <= E_HOLD;
              byte_done <= 1'b1;
              rx_load   <= !addr_byte && rx_mode;
              addr_byte <= 1'b0;
            end else begin
              bitn <= bitn + 4'd1;
              txsh <= {txsh[6:0], 1'b0};
            end
          end else ph <= ph + 2'd1;
        end
        E_HOLD: if (go) begin
          ph <= 2'd0;
          case (go_cmd)
            C_RESTART: begin
              st        <= E_START;
              txsh      <= tx_byte;
              addr_byte <= 1'b1;
            end
            C_STOP: st <= E_STOP;
            default: begin
              st   <= E_BIT;
              bitn <= '0;
              txsh <= tx_byte;
            end
          endcase
        end
        E_STOP: if (tick) begin
          if (ph == 2'd2) begin
            st <= E_IDLE;
            ph <= 2'd0;
          end else ph <= ph + 2'd1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cbm_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  output logic [7:0] stat_q,
  output logic [7:0] data_q,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low
);
  logic             ack_gen_q, pre_hi_q, ien_q, pend_q, oen_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       mode_q;
  logic [7:0]       dreg;
  step_cmd_t        cmd_q;
  logic             wr_ctrl, wr_stat, wr_dat;
  logic             go, start_req;
  logic             tick, run, byte_done, rx_load, ack_seen, busy;
  logic [7:0]       rx_byte;

  always_comb begin
    wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
    wr_stat   = wr_en && (wr_sel == SEL_STAT);
    wr_dat    = wr_en && (wr_sel == SEL_DATA);
    go        = wr_ctrl && !wr_data[4] && pend_q;
    start_req = wr_stat && wr_data[7] && wr_data[5] && wr_data[4] && !pend_q;
    ctrl_q    = {ack_gen_q, pre_hi_q, ien_q, pend_q, div_q};
    stat_q    = {mode_q, busy, oen_q, 3'b000, ack_seen};
    data_q    = dreg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_gen_q <= 1'b0;
      pre_hi_q  <= 1'b0;
      ien_q     <= 1'b0;
      pend_q    <= 1'b0;
      div_q     <= '0;
      mode_q    <= '0;
      oen_q     <= 1'b0;
      dreg      <= '0;
      cmd_q     <= C_NEXT;
      irq       <= 1'b0;
    end else begin
      irq <= pend_q && ien_q;
      if (wr_ctrl) begin
        ack_gen_q <= wr_data[7];
        pre_hi_q  <= wr_data[6];
        ien_q     <= wr_data[5];
        div_q     <= wr_data[DIV_W-1:0];
      end
      if (byte_done) pend_q <= 1'b1;
      else if (go)   pend_q <= 1'b0;
      if (wr_stat) begin
        mode_q <= wr_data[7:6];
        oen_q  <= wr_data[4];
        if (pend_q) cmd_q <= wr_data[5] ? C_RESTART : C_STOP;
      end else if (go) cmd_q <= C_NEXT;
      if (rx_load)     dreg <= rx_byte;
      else if (wr_dat) dreg <= wr_data;
    end
  end

  i2cbm_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .pre_hi(pre_hi_q), .div_sel(div_q), .tick(tick)
  );

  i2cbm_busmon u_mon (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .busy(busy)
  );

  i2cbm_engine u_eng (
    .clk(clk), .rst(rst), .tick(tick), .start_req(start_req), .go(go),
    .go_cmd(cmd_q), .rx_mode(!mode_q[0]), .ack_gen(ack_gen_q), .tx_byte(dreg),
    .sda_in(sda_in), .run(run), .scl_low(scl_low), .sda_low(sda_low),
    .byte_done(byte_done), .rx_load(rx_load), .rx_byte(rx_byte), .ack_seen(ack_seen)
  );
endmodule

// File: rtl/i2cbm_checker.sv
module i2cbm_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ctrl_q,
  input logic [7:0] stat_q,
  input logic       scl_in,
  input logic       sda_in,
  input logic       scl_low,
  input logic       sda_low
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ctrl_q == 8'h00 && stat_q == 8'h00 && !scl_low && !sda_low));

  assert_scl_held_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[4] |-> scl_low);

  assert_pend_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[4]) |-> stat_q[5]);

  assert_busy_on_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[5]) |-> ($past(scl_in) && !$past(sda_in)));

  assert_busy_off_stop_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_q[5]) |-> ($past(scl_in) && $past(sda_in)));
endmodule

bind i2c_byte_master i2cbm_checker u_chk (
  .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .stat_q(stat_q),
  .scl_in(scl_in), .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low)
);

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  localparam int CLK_P = 10;
  localparam logic [6:0] SLV_ADDR = 7'h50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_q, stat_q, data_q;
  logic       irq, scl_low, sda_low, scl_in, sda_in;
  logic       slv_low = 1'b0;

  int ntests = 0;
  int nfail  = 0;
  int cyc    = 0;

  assign scl_in = !scl_low;
  assign sda_in = !(sda_low || slv_low);

  always #(CLK_P/2) clk = !clk;

  i2c_byte_master u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .data_q(data_q), .irq(irq),
    .scl_in(scl_in), .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low)
  );

  function automatic logic [7:0] rd_val(input int i);
    return 8'h5A + 8'(i * 17);
  endfunction

  // behavioural slave and bus reference
  bit         p_scl = 1, p_sda = 1, exp_busy = 0;
  bit         s_act = 0, s_addrph = 0, s_match = 0, s_rd = 0, s_mack = 0;
  int         s_cnt = 0, s_rd_idx = 0, n_starts = 0, n_stops = 0;
  int         last_rise = 0, scl_period = 0;
  logic [7:0] s_sh = 0, s_out = 0;
  logic [7:0] s_rx_q[$];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      exp_busy = 0; s_act = 0; p_scl = 1; p_sda = 1;
      slv_low <= 1'b0;
    end else begin
      if (!p_scl && scl_in) begin
        scl_period = cyc - last_rise;
        last_rise  = cyc;
      end
      if (p_scl && scl_in && p_sda && !sda_in) begin
        exp_busy = 1; n_starts++;
        s_act = 1; s_cnt = 0; s_addrph = 1; s_match = 0;
        slv_low <= 1'b0;
      end else if (p_scl && scl_in && !p_sda && sda_in) begin
        exp_busy = 0; n_stops++; s_act = 0;
        slv_low <= 1'b0;
      end else if (s_act && !p_scl && scl_in) begin
        if (s_cnt < 8) s_sh = {s_sh[6:0], sda_in};
        else           s_mack = !sda_in;
        s_cnt++;
      end else if (s_act && p_scl && !scl_in) begin
        if (s_cnt == 8) begin
          if (s_addrph) begin
            s_match = (s_sh[7:1] == SLV_ADDR);
            s_rd    = s_sh[0];
            slv_low <= s_match;
          end else if (s_match && !s_rd) begin
            s_rx_q.push_back(s_sh);
            slv_low <= 1'b1;
          end else slv_low <= 1'b0;
        end else if (s_cnt == 9) begin
          s_cnt = 0;
          if (s_match && s_rd && (s_addrph || s_mack)) begin
            s_out = rd_val(s_rd_idx);
            s_rd_idx++;
            slv_low <= !s_out[7];
          end else slv_low <= 1'b0;
          s_addrph = 0;
        end else if (s_cnt >= 1 && s_cnt <= 7 && s_match && s_rd && !s_addrph)
          slv_low <= !s_out[7 - s_cnt];
        else slv_low <= 1'b0;
      end
      p_scl = scl_in;
      p_sda = sda_in;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      ntests++;
      if (stat_q[5] !== exp_busy) begin
        nfail++;
        $display("FAIL R6 busy per-cycle act=%0b exp=%0b at cycle %0d", stat_q[5], exp_busy, cyc);
      end
      if (ctrl_q[4] && scl_in) begin
        nfail++;
        $display("FAIL R5 scl while pending act=1 exp=0 at cycle %0d", cyc);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pend(input string tag);
    int n = 0;
    while (!ctrl_q[4] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, 16'(ctrl_q[4]), 16'h1);
  endtask

  task automatic wait_free(input string tag);
    int n = 0;
    while (stat_q[5] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, 16'(stat_q[5]), 16'h0);
    repeat (300) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int st0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", 16'(ctrl_q), 16'h00);
    chk("R1 stat", 16'(stat_q), 16'h00);
    chk("R1 data", 16'(data_q), 16'h00);
    chk("R1 lines", {14'd0, scl_low, sda_low}, 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // write transfer, prescale 16, divider 1
    wr(2'd0, 8'hA1);
    chk("R2 ctrl readback", 16'(ctrl_q), 16'hA1);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend("R3 address byte pending");
    chk("R6 ack of address", 16'(stat_q[0]), 16'h0);
    chk("R6 mode/oen readback", {8'd0, stat_q[7:6], 1'b0, stat_q[4], 4'd0}, 16'h00D0);
    chk("R2 scl period 16x2", 16'(scl_period), 16'd32);
    chk("R3 slave matched address", 16'(s_match), 16'h1);
    @(negedge clk);
    chk("R4 irq with enable", 16'(irq), 16'h1);
    repeat (100) @(negedge clk);
    chk("R5 scl held low", 16'(scl_in), 16'h0);
    wr(2'd0, 8'hB1);
    repeat (5) @(negedge clk);
    chk("R5 write of 1 keeps pending", 16'(ctrl_q[4]), 16'h1);
    wr(2'd2, 8'h3C);
    wr(2'd0, 8'hA1);
    wait_pend("R7 first data byte");
    chk("R7 slave got 3C", 16'(s_rx_q.size() > 0 ? s_rx_q[0] : 8'hxx), 16'h3C);
    wr(2'd2, 8'hC3);
    wr(2'd0, 8'hA1);
    wait_pend("R7 second data byte");
    chk("R7 slave got C3", 16'(s_rx_q.size() > 1 ? s_rx_q[1] : 8'hxx), 16'hC3);
    wr(2'd1, 8'hD0);
    repeat (20) @(negedge clk);
    chk("R10 status write keeps pending", 16'(ctrl_q[4]), 16'h1);
    st0 = n_stops;
    wr(2'd0, 8'hA1);
    wait_free("R10 busy clears after stop");
    chk("R10 lines released", {14'd0, scl_in, sda_in}, 16'h3);
    chk("R10 one stop seen", 16'(n_stops - st0), 16'h1);

    // address with no responder
    wr(2'd2, 8'h66);
    wr(2'd1, 8'hF0);
    wait_pend("R3 unmatched address pending");
    chk("R6 nack reads 1", 16'(stat_q[0]), 16'h1);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'hA1);
    wait_free("R10 stop after nack");

    // register pointer write then repeated start read
    st0 = n_starts;
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend("R3 address for pointer");
    wr(2'd2, 8'h07);
    wr(2'd0, 8'hA1);
    wait_pend("R7 pointer byte");
    wr(2'd2, 8'hA1);
    wr(2'd1, 8'hB0);
    chk("R9 busy kept before restart", 16'(stat_q[5]), 16'h1);
    wr(2'd0, 8'hA1);
    wait_pend("R9 restart address byte");
    chk("R9 two starts, no stop between", 16'(n_starts - st0), 16'h2);
    chk("R9 read address acked", 16'(stat_q[0]), 16'h0);
    wr(2'd0, 8'hA1);
    wait_pend("R8 first read byte");
    chk("R8 first byte value", 16'(data_q), 16'(rd_val(0)));
    chk("R8 master acked", 16'(s_mack), 16'h1);
    chk("R8 ack bit reads 0", 16'(stat_q[0]), 16'h0);
    wr(2'd0, 8'h31);
    wr(2'd0, 8'h21);
    wait_pend("R8 last read byte");
    chk("R8 last byte value", 16'(data_q), 16'(rd_val(1)));
    chk("R8 master nacked", 16'(s_mack), 16'h0);
    chk("R8 ack bit reads 1", 16'(stat_q[0]), 16'h1);
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h21);
    wait_free("R10 stop after read");

    // ignored status writes in idle
    st0 = n_starts;
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'h30);
    wr(2'd1, 8'hC0);
    wr(2'd1, 8'hD0);
    repeat (200) @(negedge clk);
    chk("R3 no start from ignored writes", 16'(n_starts - st0), 16'h0);
    chk("R3 bus idle", {13'd0, stat_q[5], scl_in, sda_in}, 16'h3);
    chk("R3 nothing pending", 16'(ctrl_q[4]), 16'h0);

    // prescale 512, divider 0
    wr(2'd0, 8'h60);
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'hF0);
    wait_pend("R2 address at prescale 512");
    chk("R2 scl period 512", 16'(scl_period), 16'd512);
    @(negedge clk);
    chk("R4 irq enabled", 16'(irq), 16'h1);
    wr(2'd0, 8'h50);
    @(negedge clk);
    chk("R4 irq masked", 16'(irq), 16'h0);
    chk("R4 pending still set", 16'(ctrl_q[4]), 16'h1);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h40);
    wait_free("R10 stop at prescale 512");

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule